// File: doc/BRIEF.md
# Serial Converter Capture Controller

This block runs on the host side of a serial analog-to-digital converter. The converter needs twelve of its own clocks for each sample. The block makes that converter clock from the system clock with a programmable ratio. It drives the converter's active-low start line and shifts the eight result bits in, most significant bit first. Each finished word is offered on a valid/ready output.

Two ways of running are available. A pulse on `start_req` while the block is idle runs a single frame, after which the converter clock stops. Holding `cfg_cont` high runs frames back to back with no gap until it is cleared. All bits except the last stay valid for a whole converter clock. The last bit is valid only during one low phase. For that reason every bit is sampled in the final system cycle of the low phase that carries it.

Top module: `sadc_host_capture`

## Requirements
- R1: The effective ratio is `cfg_div`, or 4 when `cfg_div` is below 4. The converter clock period is exactly that many system cycles. It is high for floor(ratio/2) cycles, then low for the rest, and it stays low whenever no frame is running.
- R2: At the trigger edge the start line goes low. The first converter rising edge (frame clock 1) follows ratio - floor(ratio/2) cycles later, and the start line is still low at that edge.
- R3: The converter launches a new bit on each falling edge of frame clocks 4 to 11. The block captures one bit per clock in the last system cycle of the low phase of clocks 4 to 11. The bit from clock 4 becomes result bit 7 and the bit from clock 11 becomes bit 0.
- R4: The last bit is taken before the rising edge of frame clock 12. The word is therefore unaffected by any change on the data line from that edge onward.
- R5: A `start_req` pulse while idle with `cfg_cont` low runs exactly one frame. The start line returns high in the cycle after the clock-1 rising edge. After the low phase of clock 12 the converter clock stays low and the start line stays high.
- R6: While `cfg_cont` is high, frames repeat every 12 x ratio system cycles with no gap, and `cfg_cont` takes priority over `start_req` at the trigger. When `cfg_cont` is cleared outside the low phase of clock 12, the current frame completes and no further frame starts.
- R7: A result stays on `res_data` with `res_valid` high until a cycle with `res_valid` and `res_ready` both high. After that cycle `res_valid` falls unless a new result lands.
- R8: A new result that arrives while the held one is unaccepted replaces it and sets `res_overrun`. The flag stays set until the next trigger from idle clears it.
- R9: While a frame sequence is active, `start_req` pulses and `cfg_div` changes have no effect. The ratio is latched at the trigger.
- R10: `res_valid` rises ratio - floor(ratio/2) + 11 x ratio system cycles after the trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | System cycles per converter clock (values below 4 act as 4) |
| cfg_cont | input | 1 | Continuous operation while high |
| start_req | input | 1 | Single-frame request pulse, honoured only when idle |
| adc_sclk | output | 1 | Converter clock |
| adc_start_n | output | 1 | Active-low start line to the converter |
| adc_dout | input | 1 | Serial data from the converter |
| res_data | output | 8 | Captured result word |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer accepts the word |
| res_overrun | output | 1 | Sticky: an unaccepted word was replaced |

## Verification
The bench builds the block with the default DIV_W of 8. It sweeps `cfg_div` from 0 to 9 in single-frame runs, which covers the clamped ratios, an even and odd duty split, and the latency formula at each ratio. A converter model in the bench checks every period and high time and deserts the last bit at the clock-12 rising edge. Continuous runs at ratio 5 (gapless timing) and at a clamped ratio 2 with the consumer stalled (overwrite and sticky flag) cover the remaining modes.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int unsigned RES_BITS      = 8;
    localparam int unsigned FIRST_BIT_CLK = 4;
    localparam int unsigned FRAME_CLKS    = FIRST_BIT_CLK + RES_BITS;
    localparam int unsigned LAST_BIT_CLK  = FIRST_BIT_CLK + RES_BITS - 1;
    localparam int unsigned MIN_RATIO     = 4;
    localparam int unsigned IDX_W         = $clog2(FRAME_CLKS + 1);

    typedef logic [RES_BITS-1:0] res_word_t;
    typedef logic [IDX_W-1:0]    frame_idx_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_FRAME
    } seq_state_e;

    typedef struct packed {
        logic trig;
        logic halt;
        logic cap;
        logic last;
    } seq_ctl_t;

    function automatic int unsigned clamp_ratio(input int unsigned r);
        return (r < MIN_RATIO) ? MIN_RATIO : r;
    endfunction

    function automatic logic in_bit_window(input frame_idx_t i);
        return (i >= IDX_W'(FIRST_BIT_CLK)) && (i <= IDX_W'(LAST_BIT_CLK));
    endfunction

endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen
    import sadc_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             halt,
    input  logic [DIV_W-1:0] ratio,
    output logic             ph_end,
    output logic             sclk
);

    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] half;
    logic             active_q;

    always_comb begin
        half   = ratio >> 1;
        ph_end = active_q && (ph_q == ratio - DIV_W'(1));
        sclk   = active_q && (ph_q < half);
    end

    // Launch enters mid-period so the first visible edge is a rising one.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= '0;
            active_q <= 1'b0;
        end else if (launch) begin
            ph_q     <= half;
            active_q <= 1'b1;
        end else if (halt) begin
            ph_q     <= '0;
            active_q <= 1'b0;
        end else if (active_q) begin
            ph_q <= ph_end ? '0 : ph_q + DIV_W'(1);
        end
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (ph_q < ratio)) else $error("phase beyond ratio"); // R1

    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(halt) |-> !sclk) else $error("clock not parked low"); // R5

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_req,
    input  logic     cont_en,
    input  logic     ph_end,
    output logic     start_n,
    output logic     busy,
    output seq_ctl_t ctl
);

    seq_state_e state_q;
    frame_idx_t idx_q;
    logic       cont_q;
    logic       start_n_q;
    logic       frame_end;

    always_comb begin
        ctl.trig  = (state_q == SQ_IDLE) && (cont_en || start_req);
        frame_end = (state_q == SQ_FRAME) && ph_end && (idx_q == IDX_W'(FRAME_CLKS));
        ctl.halt  = frame_end && start_n_q;
        ctl.cap   = (state_q == SQ_FRAME) && ph_end && in_bit_window(idx_q);
        ctl.last  = ctl.cap && (idx_q == IDX_W'(LAST_BIT_CLK));
        busy      = (state_q != SQ_IDLE);
        start_n   = start_n_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            idx_q     <= '0;
            cont_q    <= 1'b0;
            start_n_q <= 1'b1;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (ctl.trig) begin
                        state_q   <= SQ_LEAD;
                        idx_q     <= '0;
                        cont_q    <= cont_en;
                        start_n_q <= 1'b0;
                    end
                end
                SQ_LEAD: begin
                    if (ph_end) begin
                        state_q <= SQ_FRAME;
                        idx_q   <= IDX_W'(1);
                    end
                end
                SQ_FRAME: begin
                    // Single frames release the line right after clock 1.
                    start_n_q <= cont_q ? !cont_en : 1'b1;
                    if (ph_end) begin
                        if (idx_q == IDX_W'(FRAME_CLKS)) begin
                            if (start_n_q) begin
                                state_q <= SQ_IDLE;
                                idx_q   <= '0;
                            end else begin
                                idx_q <= IDX_W'(1);
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    AST_START_LOW_AT_CLK1: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_FRAME && $past(state_q) == SQ_LEAD) |-> !start_n_q)
        else $error("start line high at first edge"); // R2

    AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_FRAME && !cont_q && $past(state_q) == SQ_FRAME) |-> start_n_q)
        else $error("single frame holds start line"); // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE) |-> start_n_q) else $error("start low while idle"); // R5

    AST_FRAME_INDEX: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_FRAME) |-> (idx_q >= IDX_W'(1) && idx_q <= IDX_W'(FRAME_CLKS)))
        else $error("frame index out of range"); // R6

endmodule

// File: rtl/sadc_deser.sv
module sadc_deser
    import sadc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap,
    input  logic      last,
    input  logic      clr,
    input  logic      din,
    input  logic      ready,
    output res_word_t data,
    output logic      valid,
    output logic      overrun
);

    logic [RES_BITS-2:0] sh_q;
    res_word_t           word;

    assign word = {sh_q, din};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            data    <= '0;
            valid   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (cap) begin
                sh_q <= word[RES_BITS-2:0];
            end
            if (last) begin
                data  <= word;
                valid <= 1'b1;
            end else if (ready) begin
                valid <= 1'b0;
            end
            if (clr) begin
                overrun <= 1'b0;
            end else if (last && valid && !ready) begin
                overrun <= 1'b1;
            end
        end
    end

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !last) |=> (valid && $stable(data)))
        else $error("result dropped before acceptance"); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr) |=> overrun) else $error("overrun flag lost"); // R8

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(valid && !ready && last))
        else $error("overrun without displaced result"); // R8

endmodule

// File: rtl/sadc_host_capture.sv
module sadc_host_capture
    import sadc_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_cont,
    input  logic                start_req,
    output logic                adc_sclk,
    output logic                adc_start_n,
    input  logic                adc_dout,
    output logic [RES_BITS-1:0] res_data,
    output logic                res_valid,
    input  logic                res_ready,
    output logic                res_overrun
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] div_sel;
    logic             busy;
    logic             ph_end;
    seq_ctl_t         ctl;

    always_comb begin
        div_eff = DIV_W'(clamp_ratio(32'(cfg_div)));
        div_sel = busy ? div_q : div_eff;
    end

    // Ratio tracks the configuration only while idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_W'(MIN_RATIO);
        end else begin
            div_q <= div_sel;
        end
    end

    sadc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .cont_en   (cfg_cont),
        .ph_end    (ph_end),
        .start_n   (adc_start_n),
        .busy      (busy),
        .ctl       (ctl)
    );

    sadc_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .launch (ctl.trig),
        .halt   (ctl.halt),
        .ratio  (div_sel),
        .ph_end (ph_end),
        .sclk   (adc_sclk)
    );

    sadc_deser u_deser (
        .clk     (clk),
        .rst     (rst),
        .cap     (ctl.cap),
        .last    (ctl.last),
        .clr     (ctl.trig),
        .din     (adc_dout),
        .ready   (res_ready),
        .data    (res_data),
        .valid   (res_valid),
        .overrun (res_overrun)
    );

    AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(div_q)) else $error("ratio moved mid-run"); // R9

    AST_CAPTURE_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        ctl.cap |-> !adc_sclk) else $error("capture outside low phase"); // R3

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        busy |-> (div_q >= DIV_W'(MIN_RATIO))) else $error("ratio below floor"); // R1

endmodule

// File: tb/sadc_host_capture_test.sv
module sadc_host_capture_test;
    import sadc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_cont = 1'b0;
    logic             start_req = 1'b0;
    logic             res_ready = 1'b0;
    logic             adc_dout = 1'b0;
    logic             adc_sclk;
    logic             adc_start_n;
    logic [7:0]       res_data;
    logic             res_valid;
    logic             res_overrun;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rx_n = 0;
    int exp_div = 4;
    int m_idx = 0;
    int m_frames = 0;
    int since_rise = 0;
    logic sclk_prev = 1'b0;
    logic [7:0] m_word = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_host_capture #(.DIV_W(DIV_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .cfg_div     (cfg_div),
        .cfg_cont    (cfg_cont),
        .start_req   (start_req),
        .adc_sclk    (adc_sclk),
        .adc_start_n (adc_start_n),
        .adc_dout    (adc_dout),
        .res_data    (res_data),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_overrun (res_overrun)
    );

    function automatic logic [7:0] pat(input int n);
        if (n == 0) return 8'hFF;
        if (n == 1) return 8'h00;
        return 8'((n * 73 + 29) ^ (n >> 2));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Converter-side protocol model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst) begin
            m_idx      = 0;
            since_rise = 0;
            sclk_prev  = 1'b0;
            adc_dout   = 1'b0;
        end else begin
            if (adc_sclk && !sclk_prev) begin
                if (m_idx == 0) begin
                    check(!adc_start_n, "R2", "start line at clock 1", int'(adc_start_n), 0);
                    m_idx  = 1;
                    m_word = pat(m_frames);
                    m_frames++;
                end else begin
                    check(since_rise == exp_div, "R1", "clock period", since_rise, exp_div);
                    if (m_idx == FRAME_CLKS) begin
                        m_idx  = 1;
                        m_word = pat(m_frames);
                        m_frames++;
                    end else begin
                        m_idx++;
                    end
                end
                since_rise = 0;
                // LSB window closes here: drive the opposite value.
                if (m_idx == FRAME_CLKS) adc_dout = ~m_word[0];
            end else if (!adc_sclk && sclk_prev) begin
                check(since_rise == exp_div / 2, "R1", "clock high time", since_rise, exp_div / 2);
                if (m_idx >= 4 && m_idx <= 11) adc_dout = m_word[11 - m_idx];
                else adc_dout = 1'b0;
                if (m_idx == FRAME_CLKS && adc_start_n) m_idx = 0;
            end
            since_rise++;
            sclk_prev = adc_sclk;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected=<%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic run_one(input int d, input bit inject);
        int e;
        int lat;
        int n;
        logic [7:0] w;
        e   = (d < 4) ? 4 : d;
        lat = (e - e / 2) + 11 * e;
        w   = pat(rx_n);
        exp_div   = e;
        cfg_div   = DIV_W'(d);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        n = 1;
        while (!res_valid && n < 5000) begin
            @(negedge clk);
            n++;
            start_req = (inject && n == 30);
            if (inject && n == 30) cfg_div = DIV_W'(9);
        end
        check(n == lat + 1, "R10", "trigger-to-valid cycles", n, lat + 1);
        check(res_data == w, "R3", "captured word", int'(res_data), int'(w));
        check(res_data[0] == w[0], "R4", "last bit", int'(res_data[0]), int'(w[0]));
        rx_n++;
        repeat (e + 2) @(negedge clk);
        check(adc_sclk == 1'b0, "R5", "clock parked low", int'(adc_sclk), 0);
        check(adc_start_n == 1'b1, "R5", "start line released", int'(adc_start_n), 1);
        check(m_frames == rx_n, inject ? "R9" : "R5", "frames issued", m_frames, rx_n);
        check(res_valid && res_data == w, "R7", "word held", int'(res_data), int'(w));
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(!res_valid, "R7", "valid after accept", int'(res_valid), 0);
    endtask

    task automatic wait_next(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!res_valid && n < 5000);
    endtask

    initial begin
        int n;
        logic [7:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(adc_sclk == 1'b0, "R1", "reset clock low", int'(adc_sclk), 0);
        check(adc_start_n == 1'b1, "R5", "reset start high", int'(adc_start_n), 1);
        check(res_valid == 1'b0, "R7", "reset valid", int'(res_valid), 0);
        check(res_overrun == 1'b0, "R8", "reset overrun", int'(res_overrun), 0);

        // Single frames across clamped, even and odd ratios.
        for (int d = 0; d < 10; d++) run_one(d, 1'b0);
        // Busy-time requests and ratio change are ignored.
        run_one(6, 1'b1);

        // Continuous, gapless, consumer always ready.
        cfg_div = DIV_W'(5); exp_div = 5; res_ready = 1'b1; cfg_cont = 1'b1;
        @(negedge clk);
        n = 1;
        while (!res_valid && n < 5000) begin @(negedge clk); n++; end
        check(n == 3 + 55 + 1, "R10", "first continuous latency", n, 59);
        w = pat(rx_n);
        check(res_data == w, "R6", "continuous word 0", int'(res_data), int'(w));
        rx_n++;
        for (int i = 1; i < 5; i++) begin
            wait_next(n);
            check(n == 60, "R6", "frame spacing", n, 60);
            w = pat(rx_n);
            check(res_data == w, "R6", "continuous word", int'(res_data), int'(w));
            rx_n++;
        end
        cfg_cont = 1'b0;
        repeat (7) @(negedge clk);
        check(adc_sclk == 1'b0 && adc_start_n == 1'b1, "R6", "stopped after clear",
              int'(adc_start_n), 1);
        check(m_frames == rx_n, "R6", "continuous frame count", m_frames, rx_n);
        res_ready = 1'b0;

        // Stalled consumer, clamped ratio 2 -> 4.
        cfg_div = DIV_W'(2); exp_div = 4; cfg_cont = 1'b1;
        @(negedge clk);
        n = 1;
        while (!res_valid && n < 5000) begin @(negedge clk); n++; end
        check(n == 2 + 44 + 1, "R10", "clamped latency", n, 47);
        check(res_overrun == 1'b0, "R8", "no overrun on first word", int'(res_overrun), 0);
        rx_n++;
        repeat (48) @(negedge clk);
        w = pat(rx_n);
        check(res_valid && res_data == w, "R8", "word replaced", int'(res_data), int'(w));
        check(res_overrun == 1'b1, "R8", "overrun set", int'(res_overrun), 1);
        rx_n++;
        cfg_cont = 1'b0;
        repeat (6) @(negedge clk);
        check(m_frames == rx_n, "R6", "stalled frame count", m_frames, rx_n);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(res_overrun == 1'b1, "R8", "overrun sticky", int'(res_overrun), 1);
        cfg_div = DIV_W'(4); exp_div = 4; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(res_overrun == 1'b0, "R8", "overrun cleared on trigger", int'(res_overrun), 0);
        n = 1;
        while (!res_valid && n < 5000) begin @(negedge clk); n++; end
        w = pat(rx_n);
        check(res_data == w, "R3", "word after overrun", int'(res_data), int'(w));
        rx_n++;
        repeat (8) @(negedge clk);

        summary();
        $finish;
    end

endmodule